// File: doc/BRIEF.md
# Core-Style Destructive-Read Memory Controller

This block makes an ordinary synchronous RAM behave, at its pins, like a magnetic-core store for a 20-bit processor. Every access takes one fixed memory cycle of two halves. The first half reads the addressed word. The second half writes a word back to the same location. With a 300 ns base clock, each half lasts three clocks, so a full cycle is 1.8 µs. The word written back is normally the word just read. On a processor store it is the store data. On a front-panel deposit it is the panel data.

Two non-overlapping phase strobes, A and B, mark the first and second clock of each half. Read data is shown to the processor for two clocks, around the boundary between the halves, and a one-clock valid strobe marks it. The memory address register stays fixed for the whole cycle. The top 4K words stand for non-volatile storage. A processor store there only restores the word that was read. A front-panel deposit may change it.

Top module: `core_mem_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, busy_o, rvalid_o, phase_a_o, phase_b_o, mem_rd_o and mem_wr_o are 0 and rdata_o is 0.
- R2: When busy_o is low at a rising clock edge and fp_dep_i or req_valid_i is high, a cycle starts and busy_o is high for exactly the next 6 clocks. Requests seen while busy_o is high are ignored.
- R3: During a cycle, phase_a_o is high on clocks 0 and 3 and phase_b_o on clocks 1 and 4, counted from the first busy clock. The two are never high together, and both are low while idle.
- R4: mem_rd_o is high on clock 0 only. mem_addr_o equals the accepted address and stays stable on every busy clock.
- R5: For a processor access, rvalid_o pulses on clock 2 only. rdata_o carries the word read on clocks 2 and 3 and is 0 on every other clock.
- R6: mem_wr_o is high on clock 3 only. For a processor read it writes back the word that was read.
- R7: A processor store (req_store_i = 1) outside the protected region writes req_wdata_i.
- R8: The protected region is every address whose bits [15:12] are all 1 (0xF000 to 0xFFFF with default widths). A processor store there writes back the word read, so the location keeps its old value. Address 0xEFFF is unprotected.
- R9: A front-panel deposit writes fp_data_i at fp_addr_i, including the protected region. It gives no rvalid_o pulse and keeps rdata_o at 0. When both requests are present, the deposit wins.
- R10: A request held high through the end of a cycle is accepted on the first clock after busy_o falls, so back-to-back cycles are 7 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 300 ns base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor access request |
| req_store_i | input | 1 | 1 = store, 0 = read |
| req_addr_i | input | 16 | Processor word address |
| req_wdata_i | input | 20 | Processor store data |
| fp_dep_i | input | 1 | Front-panel deposit request |
| fp_addr_i | input | 16 | Front-panel address |
| fp_data_i | input | 20 | Front-panel deposit data |
| busy_o | output | 1 | Memory cycle in progress |
| rvalid_o | output | 1 | One-clock read-data strobe |
| rdata_o | output | 20 | Read data, shown in the two-clock window |
| phase_a_o | output | 1 | Phase A strobe |
| phase_b_o | output | 1 | Phase B strobe |
| mem_addr_o | output | 16 | RAM address, driven from the address register |
| mem_rd_o | output | 1 | RAM read enable (data returned one clock later) |
| mem_wr_o | output | 1 | RAM write enable |
| mem_wdata_o | output | 20 | RAM write data |
| mem_rdata_i | input | 20 | RAM read data |

## Verification
A slip in the tick or half counter moves the phase strobes, mem_rd_o, mem_wr_o or rvalid_o by at least one clock. The per-clock comparison catches that within the first cycle it affects. A wrong write-back choice (restore, store data or panel data, or a bad protection decode) does not show until the location is read again. The bench therefore re-reads every location it writes, and the word appears on rdata_o in that next cycle. A lost or double acceptance changes the length of the busy_o window, which shows at once.

// File: rtl/core_mem_pkg.sv
package core_mem_pkg;
  typedef enum logic [1:0] {
    ACC_READ    = 2'd0,
    ACC_STORE   = 2'd1,
    ACC_DEPOSIT = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/core_mem_seq.sv
module core_mem_seq #(
  parameter int unsigned HALF_TICKS = 3,
  localparam int unsigned TW = $clog2(HALF_TICKS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic phase_a_o,
  output logic phase_b_o,
  output logic rd_stb_o,
  output logic cap_o,
  output logic show_o,
  output logic wr_stb_o,
  output logic rvalid_slot_o
);
  localparam logic [TW-1:0] LAST = TW'(HALF_TICKS - 1);

  logic          busy_q;
  logic          half_q;   // 0: read half, 1: write-back half
  logic [TW-1:0] tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      half_q <= 1'b0;
      tick_q <= '0;
    end else if (!busy_q) begin
      busy_q <= start_i;
      half_q <= 1'b0;
      tick_q <= '0;
    end else if (tick_q == LAST) begin
      tick_q <= '0;
      half_q <= ~half_q;
      if (half_q) busy_q <= 1'b0;
    end else begin
      tick_q <= tick_q + 1'b1;
    end
  end

  assign busy_o        = busy_q;
  assign phase_a_o     = busy_q && (tick_q == '0);
  assign phase_b_o     = busy_q && (tick_q == TW'(1));
  assign rd_stb_o      = busy_q && !half_q && (tick_q == '0);
  // RAM returns data one clock after the read strobe
  assign cap_o         = busy_q && !half_q && (tick_q == TW'(1));
  assign rvalid_slot_o = busy_q && !half_q && (tick_q == LAST);
  assign wr_stb_o      = busy_q &&  half_q && (tick_q == '0);
  assign show_o        = rvalid_slot_o || wr_stb_o;
endmodule

// File: rtl/core_mem_dpath.sv
module core_mem_dpath
  import core_mem_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 20,
  parameter int unsigned NV_W   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  acc_kind_e         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mdr_o,
  output logic [DATA_W-1:0] wdata_o,
  output acc_kind_e         kind_o
);
  logic [ADDR_W-1:0] mar_q;
  logic [DATA_W-1:0] mdr_q;
  logic [DATA_W-1:0] new_q;
  acc_kind_e         kind_q;
  logic              prot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mar_q  <= '0;
      mdr_q  <= '0;
      new_q  <= '0;
      kind_q <= ACC_READ;
    end else begin
      if (start_i) begin
        mar_q  <= addr_i;
        new_q  <= data_i;
        kind_q <= kind_i;
      end
      if (cap_i) mdr_q <= mem_rdata_i;
    end
  end

  generate
    if (NV_W < ADDR_W) begin : g_prot
      assign prot = &mar_q[ADDR_W-1:NV_W];
    end else begin : g_all_prot
      assign prot = 1'b1;
    end
  endgenerate

  always_comb begin
    unique case (kind_q)
      ACC_DEPOSIT: wdata_o = new_q;
      ACC_STORE:   wdata_o = prot ? mdr_q : new_q;
      default:     wdata_o = mdr_q;
    endcase
  end

  assign mar_o  = mar_q;
  assign mdr_o  = mdr_q;
  assign kind_o = kind_q;
endmodule

// File: rtl/core_mem_ctrl.sv
module core_mem_ctrl
  import core_mem_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 20,
  parameter int unsigned NV_W       = 12,
  parameter int unsigned HALF_TICKS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              fp_dep_i,
  input  logic [ADDR_W-1:0] fp_addr_i,
  input  logic [DATA_W-1:0] fp_data_i,
  output logic              busy_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              phase_a_o,
  output logic              phase_b_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic              start;
  acc_kind_e         new_kind;
  acc_kind_e         cur_kind;
  logic [ADDR_W-1:0] new_addr;
  logic [DATA_W-1:0] new_data;
  logic [DATA_W-1:0] mdr;
  logic              cap, show, rvalid_slot;

  // panel deposit has priority over the processor
  assign start    = !busy_o && (fp_dep_i || req_valid_i);
  assign new_kind = fp_dep_i ? ACC_DEPOSIT : (req_store_i ? ACC_STORE : ACC_READ);
  assign new_addr = fp_dep_i ? fp_addr_i : req_addr_i;
  assign new_data = fp_dep_i ? fp_data_i : req_wdata_i;

  core_mem_seq #(.HALF_TICKS(HALF_TICKS)) i_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start),
    .busy_o        (busy_o),
    .phase_a_o     (phase_a_o),
    .phase_b_o     (phase_b_o),
    .rd_stb_o      (mem_rd_o),
    .cap_o         (cap),
    .show_o        (show),
    .wr_stb_o      (mem_wr_o),
    .rvalid_slot_o (rvalid_slot)
  );

  core_mem_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NV_W(NV_W)) i_dpath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .kind_i      (new_kind),
    .addr_i      (new_addr),
    .data_i      (new_data),
    .cap_i       (cap),
    .mem_rdata_i (mem_rdata_i),
    .mar_o       (mem_addr_o),
    .mdr_o       (mdr),
    .wdata_o     (mem_wdata_o),
    .kind_o      (cur_kind)
  );

  assign rvalid_o = rvalid_slot && (cur_kind != ACC_DEPOSIT);
  assign rdata_o  = (show && (cur_kind != ACC_DEPOSIT)) ? mdr : '0;
endmodule

// File: rtl/core_mem_ctrl_chk.sv
module core_mem_ctrl_chk
  import core_mem_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 20,
  parameter int unsigned NV_W       = 12,
  parameter int unsigned HALF_TICKS = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              rvalid_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              phase_a_o,
  input logic              phase_b_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input acc_kind_e         kind_i
);
  logic [15:0] run_q;
  logic        prot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  assign prot = (NV_W < ADDR_W) ? (mem_addr_o >> NV_W) == ((1 << (ADDR_W - NV_W)) - 1) : 1'b1;

  // R3
  phase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(phase_a_o && phase_b_o));

  // R3
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !phase_a_o && !phase_b_o && !mem_rd_o && !mem_wr_o && !rvalid_o);

  // R2
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == 16'(2 * HALF_TICKS));

  // R4
  mar_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(mem_addr_o));

  // R5
  rvalid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  // R6
  restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o && kind_i == ACC_READ |-> mem_wdata_o == rdata_o);

  // R8
  nv_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o && kind_i == ACC_STORE && prot |-> mem_wdata_o == rdata_o);
endmodule

bind core_mem_ctrl core_mem_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NV_W(NV_W), .HALF_TICKS(HALF_TICKS)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .rvalid_o    (rvalid_o),
  .rdata_o     (rdata_o),
  .phase_a_o   (phase_a_o),
  .phase_b_o   (phase_b_o),
  .mem_addr_o  (mem_addr_o),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .mem_wdata_o (mem_wdata_o),
  .kind_i      (cur_kind)
);

// File: tb/test_core_mem_ctrl.sv
module test_core_mem_ctrl;
  localparam int CLK_PERIOD = 300;
  localparam int AW = 16;
  localparam int DW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_store = 1'b0, fp_dep = 1'b0;
  logic [AW-1:0] req_addr = '0, fp_addr = '0;
  logic [DW-1:0] req_wdata = '0, fp_data = '0;
  logic          busy, rvalid, ph_a, ph_b, mem_rd, mem_wr;
  logic [DW-1:0] rdata, mem_wdata, ram_q;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_mem_ctrl i_core_mem_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_store_i(req_store), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .fp_dep_i(fp_dep), .fp_addr_i(fp_addr), .fp_data_i(fp_data),
    .busy_o(busy), .rvalid_o(rvalid), .rdata_o(rdata),
    .phase_a_o(ph_a), .phase_b_o(ph_b),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(ram_q)
  );

  // RAM storage and reference model
  logic [DW-1:0] ram [int];
  int            t_m = -1;      // clock within cycle, -1 idle
  int            m_kind = 0;    // 0 read, 1 store, 2 deposit
  int            m_addr = 0;
  logic [DW-1:0] m_new = '0, m_rd = '0;

  function automatic logic [DW-1:0] ram_get(int a);
    if (ram.exists(a)) return ram[a];
    return DW'((a * 37 + 5) & 32'hFFFFF);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_m = -1;
      ram_q <= '0;
    end else begin
      if (t_m == -1) begin
        if (fp_dep) begin
          t_m = 0; m_kind = 2; m_addr = int'(fp_addr); m_new = fp_data;
        end else if (req_valid) begin
          t_m = 0; m_kind = req_store ? 1 : 0; m_addr = int'(req_addr); m_new = req_wdata;
        end
        if (t_m == 0) m_rd = ram_get(m_addr);
      end else if (t_m == 5) t_m = -1;
      else t_m = t_m + 1;
      if (mem_rd) ram_q <= ram_get(int'(mem_addr));
      if (mem_wr) ram[int'(mem_addr)] = mem_wdata;
    end
  end

  task automatic check(string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s t=%0d actual=%h expected=%h", rq, what, t_m, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_wdata();
    if (m_kind == 2) return m_new;
    if (m_kind == 1 && m_addr < 32'hF000) return m_new; // R7, R8
    return m_rd;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      logic act_cyc;
      act_cyc = (t_m >= 0);
      check("R2", "busy", 32'(busy), 32'(act_cyc));
      check("R3", "phase_a", 32'(ph_a), 32'(t_m == 0 || t_m == 3));
      check("R3", "phase_b", 32'(ph_b), 32'(t_m == 1 || t_m == 4));
      check("R4", "mem_rd", 32'(mem_rd), 32'(t_m == 0));
      check("R6", "mem_wr", 32'(mem_wr), 32'(t_m == 3));
      if (act_cyc) check("R4", "mem_addr", 32'(mem_addr), 32'(m_addr));
      if (t_m == 3) check(m_kind == 2 ? "R9" : (m_kind == 1 ? "R7_R8" : "R6"),
                          "mem_wdata", 32'(mem_wdata), 32'(exp_wdata()));
      check(m_kind == 2 ? "R9" : "R5", "rvalid", 32'(rvalid), 32'(t_m == 2 && m_kind != 2));
      check(m_kind == 2 ? "R9" : "R5", "rdata", 32'(rdata),
            ((t_m == 2 || t_m == 3) && m_kind != 2) ? 32'(m_rd) : 32'd0);
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (t_m != -1) @(negedge clk);
  endtask

  task automatic cpu(input int a, input logic [DW-1:0] d, input logic st);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_store = 1'b0;
    wait_idle();
  endtask

  task automatic panel(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    fp_dep = 1'b1; fp_addr = AW'(a); fp_data = d;
    @(negedge clk);
    fp_dep = 1'b0;
    wait_idle();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", "busy", 32'(busy), 0);
    check("R1", "rvalid", 32'(rvalid), 0);
    check("R1", "phases", 32'({ph_a, ph_b}), 0);
    check("R1", "mem_rd_wr", 32'({mem_rd, mem_wr}), 0);
    check("R1", "rdata", 32'(rdata), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "busy after release", 32'(busy), 0);

    cpu(16'h0123, '0, 1'b0);            // R5 R6 plain read and restore
    cpu(16'h0123, 20'hABCDE, 1'b1);     // R7 store
    cpu(16'h0123, '0, 1'b0);            // R7 read back
    cpu(16'hEFFF, 20'h12345, 1'b1);     // R8 just below the region
    cpu(16'hEFFF, '0, 1'b0);
    cpu(16'hF000, 20'h55555, 1'b1);     // R8 lowest protected word
    cpu(16'hF000, '0, 1'b0);
    cpu(16'hFFFF, 20'h0F0F0, 1'b1);     // R8 highest protected word
    cpu(16'hFFFF, '0, 1'b0);
    panel(16'hF000, 20'hBEEF1);         // R9 deposit into region
    cpu(16'hF000, '0, 1'b0);
    panel(16'h0200, 20'h00042);         // R9 deposit below region
    cpu(16'h0200, '0, 1'b0);

    // R9 both at once: deposit wins
    @(negedge clk);
    fp_dep = 1'b1; fp_addr = 16'h0300; fp_data = 20'h77777;
    req_valid = 1'b1; req_store = 1'b1; req_addr = 16'h0301; req_wdata = 20'h11111;
    @(negedge clk);
    fp_dep = 1'b0; req_valid = 1'b0; req_store = 1'b0;
    wait_idle();
    cpu(16'h0300, '0, 1'b0);
    cpu(16'h0301, '0, 1'b0);

    // R2 requests during busy are ignored
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h0400;
    @(negedge clk);
    req_addr = 16'h0401; req_store = 1'b1; req_wdata = 20'h99999;
    fp_dep = 1'b1; fp_addr = 16'h0402; fp_data = 20'h88888;
    repeat (3) @(negedge clk);
    req_valid = 1'b0; req_store = 1'b0; fp_dep = 1'b0;
    wait_idle();
    cpu(16'h0401, '0, 1'b0);
    cpu(16'h0402, '0, 1'b0);

    // R10 back-to-back held request
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h0500;
    repeat (20) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();

    // varied pattern sweep
    for (int i = 0; i < 8; i++) begin
      cpu(32'h1000 + i * 3, DW'(i * 32'h2345), 1'b1);
      cpu(32'h1000 + i * 3, '0, 1'b0);
    end

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule